// File: doc/BRIEF.md
# USB Endpoint Handshake Control

This block sits beside the serial interface engine (SIE) of a full-speed USB device and decides, for one endpoint, which handshake goes back to the host when an IN or OUT token arrives. The processor sets the endpoint up through a byte-wide register port with two locations. Offset 0 is the control register. Offset 1 holds the byte count that the SIE uses as the length of the next IN data packet.

The two mode bits form a small state machine:

| State | Mode bits | Reply to a token |
|---|---|---|
| `ST_NAK` | 00 | NAK |
| `ST_ARMED` | 01 | ACK |
| `ST_STALL` | 10 | STALL |
| `ST_STALL_HI` | 11 | STALL |

A processor write to offset 0 loads any of these states. The SIE pulses `ack_done` for one cycle when an ACKed transaction finishes. That pulse clears the low mode bit, which gives two transitions:
- `ST_ARMED` → `ST_NAK`
- `ST_STALL_HI` → `ST_STALL`

As a result, each arm lets exactly one transfer through. After that transfer the endpoint falls back to NAK until the processor arms it again. While the enable bit is clear, tokens get no handshake at all.

Top module: `usb_ep_hs_ctrl`

## Requirements
- R1: After reset the control register (offset 0) reads 0x00, the count register (offset 1) reads 0x00, `byte_cnt` is 0, and a token gets handshake code 00 (none).
- R2: A write to offset 0 stores the enable bit at bit 7 and the mode field at bits 6:5. Bits 4:0 read back as 0 whatever was written.
- R3: A write to offset 1 stores a 6-bit count at bits 5:0. That count drives `byte_cnt`, and bits 7:6 read back as 0.
- R4: While the enable bit is 0, `hs_code` is 00 (none) for every mode, even with `tok_valid` high.
- R5: Enabled with mode 00, a token gets handshake code 10 (NAK).
- R6: Enabled with mode 01, a token gets handshake code 01 (ACK).
- R7: Enabled with mode 10 or mode 11, a token gets handshake code 11 (STALL).
- R8: An `ack_done` pulse clears mode bit 5 at the next clock edge. Mode 01 becomes 00, after which tokens get NAK. The enable bit and `byte_cnt` are not changed.
- R9: When a write to offset 0 falls in the same cycle as `ack_done`, the written value is stored unchanged.
- R10: While `tok_valid` is low, `hs_code` is 00 (none).
- R11: An `ack_done` pulse in mode 10 leaves the mode at 10. In mode 11 it leaves 10. In both cases tokens still get STALL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 1 | Register offset (0 control, 1 count) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for `cpu_addr`, combinational |
| tok_valid | input | 1 | An IN or OUT token for this endpoint is present |
| ack_done | input | 1 | One-cycle pulse: an ACKed transaction has completed |
| hs_code | output | 2 | Handshake to send: 00 none, 01 ACK, 10 NAK, 11 STALL |
| byte_cnt | output | 6 | Byte count for the next IN transaction |

## Verification
Handshake selection is tried with a token against each of the four modes in both enable states. This separates the enable gate from the mode decode, and the two STALL encodings from each other. The auto-clear is driven from every mode, which shows that only the low bit drops and that the STALL modes keep stalling. It is also driven in the same cycle as a control write, to show which source wins. Count writes use values with the top bit set and with bits 7:6 set, so that field truncation and the independence of the count from the auto-clear are both visible.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_NAK   = 2'b10,
        HS_STALL = 2'b11
    } hs_code_t;

    typedef enum logic [1:0] {
        ST_NAK      = 2'b00,
        ST_ARMED    = 2'b01,
        ST_STALL    = 2'b10,
        ST_STALL_HI = 2'b11
    } ep_mode_t;

    localparam int REG_W    = 8;
    localparam int EN_BIT   = 7;
    localparam int MODE_LSB = 5;

endpackage

// File: rtl/usb_ep_mode_fsm.sv
module usb_ep_mode_fsm
    import usb_ep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic       wr_en,
    input  logic [1:0] wr_mode,
    input  logic       ack_done,
    output logic       en_o,
    output ep_mode_t   mode_o
);

    ep_mode_t state_q, state_d;
    logic     en_q, en_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_NAK;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            en_q    <= en_d;
        end
    end

    // next state: processor write beats the auto-clear
    always_comb begin
        state_d = state_q;
        en_d    = en_q;
        if (ctrl_wr) begin
            state_d = ep_mode_t'(wr_mode);
            en_d    = wr_en;
        end else if (ack_done) begin
            unique case (state_q)
                ST_NAK:      state_d = ST_NAK;
                ST_ARMED:    state_d = ST_NAK;
                ST_STALL:    state_d = ST_STALL;
                ST_STALL_HI: state_d = ST_STALL;
            endcase
        end
    end

    // outputs
    always_comb begin
        en_o   = en_q;
        mode_o = state_q;
    end

endmodule

// File: rtl/usb_ep_count_reg.sv
module usb_ep_count_reg #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] wr_cnt,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_wr) cnt_q <= wr_cnt;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/usb_ep_hs_decode.sv
module usb_ep_hs_decode
    import usb_ep_pkg::*;
(
    input  logic     tok_valid,
    input  logic     en,
    input  ep_mode_t mode,
    output hs_code_t hs
);

    always_comb begin
        hs = HS_NONE;
        if (tok_valid && en) begin
            unique case (mode)
                ST_NAK:      hs = HS_NAK;
                ST_ARMED:    hs = HS_ACK;
                ST_STALL:    hs = HS_STALL;
                ST_STALL_HI: hs = HS_STALL;
            endcase
        end
    end

endmodule

// File: rtl/usb_ep_hs_ctrl.sv
module usb_ep_hs_ctrl
    import usb_ep_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr,
    input  logic             cpu_addr,
    input  logic [7:0]       cpu_wdata,
    output logic [7:0]       cpu_rdata,
    input  logic             tok_valid,
    input  logic             ack_done,
    output logic [1:0]       hs_code,
    output logic [CNT_W-1:0] byte_cnt
);

    localparam int PAD_W = REG_W - CNT_W;

    logic     ctrl_wr, cnt_wr;
    logic     en_s;
    ep_mode_t mode_s;
    hs_code_t hs_s;
    logic     unused_wbits;

    assign ctrl_wr      = cpu_wr && (cpu_addr == 1'b0);
    assign cnt_wr       = cpu_wr && (cpu_addr == 1'b1);
    assign unused_wbits = ^cpu_wdata[REG_W-1:CNT_W];

    usb_ep_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .wr_en    (cpu_wdata[EN_BIT]),
        .wr_mode  (cpu_wdata[MODE_LSB+1:MODE_LSB]),
        .ack_done (ack_done),
        .en_o     (en_s),
        .mode_o   (mode_s)
    );

    usb_ep_count_reg #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_wr (cnt_wr),
        .wr_cnt (cpu_wdata[CNT_W-1:0]),
        .cnt_o  (byte_cnt)
    );

    usb_ep_hs_decode u_dec (
        .tok_valid (tok_valid),
        .en        (en_s),
        .mode      (mode_s),
        .hs        (hs_s)
    );

    assign hs_code   = hs_s;
    assign cpu_rdata = cpu_addr ? {{PAD_W{1'b0}}, byte_cnt}
                                : {en_s, mode_s, {MODE_LSB{1'b0}}};

endmodule

// File: rtl/usb_ep_hs_ctrl_chk.sv
module usb_ep_hs_ctrl_chk #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_wr,
    input logic             cnt_wr,
    input logic [1:0]       wmode,
    input logic             tok_valid,
    input logic             ack_done,
    input logic             en_s,
    input logic [1:0]       mode_s,
    input logic [1:0]       hs_code,
    input logic [CNT_W-1:0] byte_cnt
);

    a_r10_idle_none: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_valid |-> hs_code == 2'b00);

    a_r4_disabled_none: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && !en_s) |-> hs_code == 2'b00);

    a_r6_armed_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && en_s && mode_s == 2'b01) |-> hs_code == 2'b01);

    a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && en_s && mode_s[1]) |-> hs_code == 2'b11);

    a_r8_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_done && !ctrl_wr && mode_s == 2'b01) |=> mode_s == 2'b00);

    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> mode_s == $past(wmode));

    a_r8_count_held: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> $stable(byte_cnt));

endmodule

bind usb_ep_hs_ctrl usb_ep_hs_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .cnt_wr    (cnt_wr),
    .wmode     (cpu_wdata[6:5]),
    .tok_valid (tok_valid),
    .ack_done  (ack_done),
    .en_s      (en_s),
    .mode_s    (mode_s),
    .hs_code   (hs_code),
    .byte_cnt  (byte_cnt)
);

// File: tb/usb_ep_hs_ctrl_bench.sv
module usb_ep_hs_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0;
    logic       cpu_addr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       tok_valid = 1'b0;
    logic       ack_done = 1'b0;
    logic [1:0] hs_code;
    logic [5:0] byte_cnt;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    usb_ep_hs_ctrl u_usb_ep_hs_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .tok_valid (tok_valid),
        .ack_done  (ack_done),
        .hs_code   (hs_code),
        .byte_cnt  (byte_cnt)
    );

    localparam logic [1:0] NONE = 2'b00, ACK = 2'b01, NAK = 2'b10, STALL = 2'b11;

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_wdata = 8'h00;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        cpu_addr = a;
        #1 d = cpu_rdata;
    endtask

    task automatic token(output logic [1:0] h);
        tok_valid = 1'b1;
        #1 h = hs_code;
        tok_valid = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        ack_done = 1'b1;
        @(negedge clk);
        ack_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d; logic [1:0] h;
        rd(1'b0, d); check("R1 ctrl", d, 8'h00);
        rd(1'b1, d); check("R1 count", d, 8'h00);
        check("R1 byte_cnt", {2'b0, byte_cnt}, 8'h00);
        token(h); check("R1 hs", {6'b0, h}, {6'b0, NONE});
    endtask

    task automatic t_ctrl_fields();
        logic [7:0] d;
        wr(1'b0, 8'hFF); rd(1'b0, d); check("R2 ff", d, 8'hE0);
        wr(1'b0, 8'h5F); rd(1'b0, d); check("R2 5f", d, 8'h40);
    endtask

    task automatic t_count();
        logic [7:0] d;
        wr(1'b1, 8'hE5); rd(1'b1, d); check("R3 read", d, 8'h25);
        check("R3 byte_cnt", {2'b0, byte_cnt}, 8'h25);
        wr(1'b1, 8'h3F); rd(1'b1, d); check("R3 max", d, 8'h3F);
    endtask

    task automatic t_disabled();
        logic [1:0] h;
        for (int m = 0; m < 4; m++) begin
            wr(1'b0, {1'b0, m[1:0], 5'b0});
            token(h); check("R4 disabled", {6'b0, h}, {6'b0, NONE});
        end
    endtask

    task automatic t_modes();
        logic [1:0] h;
        wr(1'b0, 8'h80); token(h); check("R5 nak", {6'b0, h}, {6'b0, NAK});
        wr(1'b0, 8'hA0); token(h); check("R6 ack", {6'b0, h}, {6'b0, ACK});
        wr(1'b0, 8'hC0); token(h); check("R7 stall10", {6'b0, h}, {6'b0, STALL});
        wr(1'b0, 8'hE0); token(h); check("R7 stall11", {6'b0, h}, {6'b0, STALL});
    endtask

    task automatic t_idle();
        wr(1'b0, 8'hA0);
        #1 check("R10 idle", {6'b0, hs_code}, {6'b0, NONE});
    endtask

    task automatic t_autoclear();
        logic [7:0] d; logic [1:0] h;
        wr(1'b1, 8'h12);
        wr(1'b0, 8'hA0);
        pulse_ack();
        rd(1'b0, d); check("R8 ctrl", d, 8'h80);
        token(h); check("R8 nak after", {6'b0, h}, {6'b0, NAK});
        check("R8 count kept", {2'b0, byte_cnt}, 8'h12);
        pulse_ack();
        rd(1'b0, d); check("R8 nak stays", d, 8'h80);
    endtask

    task automatic t_collision();
        logic [7:0] d; logic [1:0] h;
        wr(1'b0, 8'hA0);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = 1'b0; cpu_wdata = 8'hA0; ack_done = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0; ack_done = 1'b0; cpu_wdata = 8'h00;
        rd(1'b0, d); check("R9 write wins", d, 8'hA0);
        token(h); check("R9 ack", {6'b0, h}, {6'b0, ACK});
    endtask

    task automatic t_stall_clear();
        logic [7:0] d; logic [1:0] h;
        wr(1'b0, 8'hC0); pulse_ack();
        rd(1'b0, d); check("R11 mode10", d, 8'hC0);
        wr(1'b0, 8'hE0); pulse_ack();
        rd(1'b0, d); check("R11 mode11", d, 8'hC0);
        token(h); check("R11 stall", {6'b0, h}, {6'b0, STALL});
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_ctrl_fields();
                t_count();
                t_disabled();
                t_modes();
                t_idle();
                t_autoclear();
                t_collision();
                t_stall_clear();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule